// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block serialises bytes onto one data line, either as an asynchronous framed transmitter or as a half-duplex synchronous transmitter. In synchronous operation it either produces the shift clock itself from the baud tick (master) or follows a clock arriving from outside (slave). Software sees one byte-wide control/status register and one data-buffer write port. A buffered byte moves into the shifter as soon as the shifter is idle and transmission is permitted.

Transmission is permitted only while the transmit-enable field is set. In synchronous operation, an active single-shot or continuous receive request takes priority over transmit and cancels it. A port-enable input gates both pin output enables. The controller is one state machine. Its states are IDLE (shifter empty, line high), START (asynchronous start bit), DATA (asynchronous data bits), STOP (asynchronous stop bit), SLO (synchronous bit presented, clock low) and SHI (synchronous clock high). Its transitions are:

- load: IDLE to START or SLO.
- bit_done: START to DATA, DATA to DATA, DATA to STOP, and STOP to IDLE.
- clk_rise: SLO to SHI.
- clk_fall: SHI to SLO, or SHI to IDLE after the last bit.
- abort: any busy state to IDLE when transmission stops being permitted.

Top module: `dmtx_serial_tx`

## Requirements
- R1: After reset the control read value is 8'h02, the data line is 1, the clock output is 0, and both the buffer-empty and shifter-empty flags are 1.
- R2: The control read value has the following layout. Bit 7 is the clock-master select. Bit 6 is the 9-bit select. Bit 5 is transmit enable. Bit 4 is synchronous mode. Bit 3 always reads 0. Bit 2 is fast baud. Bit 1 is the shifter-empty flag, which software writes do not change. Bit 0 is the ninth data bit. Writes take effect on the next cycle.
- R3: A buffer write sets buffer-empty to 0 on the next cycle. If the shifter is idle and transmission is permitted, the next edge loads the shifter: buffer-empty returns to 1 and shifter-empty falls to 0 in the same cycle.
- R4: An asynchronous frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. The data line is 1 whenever the shifter is idle.
- R5: In asynchronous mode each bit lasts 16 baud ticks with fast baud set and 64 ticks with it clear. With a tick on every cycle, an 8-bit frame keeps shifter-empty at 0 for 160 or 640 cycles.
- R6: With the 9-bit select set, the frame carries a ninth data bit taken from control bit 0 at load time. The frame is then one bit longer: 176 busy cycles with fast baud and a tick on every cycle.
- R7: As synchronous master, the block drives the clock output low when idle. It gives exactly 8 (or 9) high pulses per word, each clock phase lasting one baud tick. The data line changes only as the clock falls. The clock output enable is 1 when the port is enabled.
- R8: As synchronous slave, the block shifts on the rising and falling edges of the external clock after a two-flop synchroniser, and never drives the clock (clock output enable 0). In asynchronous mode the clock-master select is ignored and no clock is driven.
- R9: Fast baud has no effect in synchronous mode. A master word takes 16 busy cycles with a tick on every cycle, whichever value fast baud has.
- R10: With transmit enable clear, a buffered byte stays in the buffer and is not sent. In synchronous mode, an active receive request blocks loading and cancels a word in progress, so shifter-empty is 1 on the next cycle. In asynchronous mode, receive requests have no effect.
- R11: With the port disabled, both the data output enable and the clock output enable are 0.
- R12: Shifter-empty is 1 exactly when the shifter holds no word, and clearing transmit enable returns the shifter to empty on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control/status read value |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | DATA_W | Data buffer write value |
| baud_tick | input | 1 | Baud-rate tick, one cycle wide |
| ext_clk | input | 1 | External shift clock for slave mode |
| rx_single | input | 1 | Single-shot receive request |
| rx_cont | input | 1 | Continuous receive request |
| port_en | input | 1 | Serial port enable |
| tx_dat | output | 1 | Serial data line |
| dat_oe | output | 1 | Data line output enable |
| sclk_out | output | 1 | Synchronous shift clock output |
| sclk_oe | output | 1 | Shift clock output enable |
| buf_empty | output | 1 | Data buffer empty |
| sr_empty | output | 1 | Shifter empty |

## Verification
The assertions check a set of properties on every cycle:

- The line is high and the clock is low whenever the shifter is idle.
- The port-disable gating holds.
- No clock is driven unless the block is the synchronous master.
- Every load is preceded by a full buffer.
- A cleared transmit enable or a synchronous receive request leaves the shifter empty one cycle later.

Bit order, start/stop framing, the ninth bit, bit durations for both baud speeds, master pulse counts and slave shifting on external clock edges depend on whole frames. Only the bench's behavioural model, compared on every clock, and its timed scenarios can show these.

// File: rtl/dmtx_pkg.sv
package dmtx_pkg;

    // Control register bit positions; software decodes this layout.
    localparam int BIT_MASTER = 7;
    localparam int BIT_NINE   = 6;
    localparam int BIT_TXEN   = 5;
    localparam int BIT_SYNC   = 4;
    localparam int BIT_FAST   = 2;
    localparam int BIT_SREMP  = 1;
    localparam int BIT_NINTH  = 0;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_SLO   = 3'd4,
        ST_SHI   = 3'd5
    } dmtx_state_t;

    typedef struct packed {
        logic master;
        logic nine;
        logic txen;
        logic sync;
        logic fast;
        logic ninth;
    } dmtx_ctl_t;

endpackage

// File: rtl/dmtx_ctrl_reg.sv
module dmtx_ctrl_reg
    import dmtx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       sr_empty,
    output dmtx_ctl_t  ctl,
    output logic [7:0] rdata
);

    // Bits 3 and 1 carry no writable state.
    logic unused_wbits;
    assign unused_wbits = wdata[3] ^ wdata[BIT_SREMP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr) begin
            ctl.master <= wdata[BIT_MASTER];
            ctl.nine   <= wdata[BIT_NINE];
            ctl.txen   <= wdata[BIT_TXEN];
            ctl.sync   <= wdata[BIT_SYNC];
            ctl.fast   <= wdata[BIT_FAST];
            ctl.ninth  <= wdata[BIT_NINTH];
        end
    end

    always_comb begin
        rdata             = '0;
        rdata[BIT_MASTER] = ctl.master;
        rdata[BIT_NINE]   = ctl.nine;
        rdata[BIT_TXEN]   = ctl.txen;
        rdata[BIT_SYNC]   = ctl.sync;
        rdata[BIT_FAST]   = ctl.fast;
        rdata[BIT_SREMP]  = sr_empty;
        rdata[BIT_NINTH]  = ctl.ninth;
    end

endmodule

// File: rtl/dmtx_clk_sync.sv
module dmtx_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic rise,
    output logic fall
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[DEPTH-2:0], ext_clk};
        end
    end

    // Edge seen between the last synchronised stage and the history stage.
    assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] &  pipe[STAGES];

endmodule

// File: rtl/dmtx_bit_timer.sv
module dmtx_bit_timer #(
    parameter int SLOW_TICKS = 64,
    parameter int FAST_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic fast,
    output logic done
);

    localparam int CW = (SLOW_TICKS > 1) ? $clog2(SLOW_TICKS) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(FAST_TICKS - 1) : CW'(SLOW_TICKS - 1);
    assign done = run & tick & (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dmtx_serial_tx.sv
module dmtx_serial_tx
    import dmtx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SLOW_TICKS  = 64,
    parameter int FAST_TICKS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              baud_tick,
    input  logic              ext_clk,
    input  logic              rx_single,
    input  logic              rx_cont,
    input  logic              port_en,
    output logic              tx_dat,
    output logic              dat_oe,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              buf_empty,
    output logic              sr_empty
);

    localparam int FRAME_W = DATA_W + 1;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    dmtx_ctl_t   ctl;
    dmtx_state_t state_q, state_d;
    logic [FRAME_W-1:0] sh_q, sh_d;
    logic [IDX_W-1:0]   idx_q, idx_d, last_q, last_d;
    logic               buf_full_q;
    logic [DATA_W-1:0]  buf_q;
    logic               go, load, bit_done, timer_run;
    logic               ext_rise, ext_fall, adv_lo, adv_hi;

    dmtx_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (ctl_wdata),
        .sr_empty (sr_empty),
        .ctl      (ctl),
        .rdata    (ctl_rdata)
    );

    dmtx_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .rise    (ext_rise),
        .fall    (ext_fall)
    );

    dmtx_bit_timer #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (baud_tick),
        .fast  (ctl.fast),
        .done  (bit_done)
    );

    // Receive requests override transmit only in synchronous mode.
    assign go        = ctl.txen & ~(ctl.sync & (rx_single | rx_cont));
    assign load      = (state_q == ST_IDLE) & buf_full_q & go;
    assign timer_run = (state_q == ST_START) | (state_q == ST_DATA) | (state_q == ST_STOP);
    assign adv_lo    = ctl.master ? baud_tick : ext_rise;
    assign adv_hi    = ctl.master ? baud_tick : ext_fall;

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        idx_d   = idx_q;
        last_d  = last_q;
        if (state_q != ST_IDLE && !go) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        sh_d    = {ctl.ninth, buf_q};
                        idx_d   = '0;
                        last_d  = ctl.nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
                        state_d = ctl.sync ? ST_SLO : ST_START;
                    end
                end
                ST_START: begin
                    if (bit_done) state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (bit_done) begin
                        if (idx_q == last_q) begin
                            state_d = ST_STOP;
                        end else begin
                            sh_d  = sh_q >> 1;
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_done) state_d = ST_IDLE;
                end
                ST_SLO: begin
                    if (adv_lo) state_d = ST_SHI;
                end
                ST_SHI: begin
                    if (adv_hi) begin
                        if (idx_q == last_q) begin
                            state_d = ST_IDLE;
                        end else begin
                            sh_d    = sh_q >> 1;
                            idx_d   = idx_q + 1'b1;
                            state_d = ST_SLO;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            idx_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            idx_q   <= idx_d;
            last_q  <= last_d;
        end
    end

    // Holding buffer: a same-cycle write refills it after a load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full_q <= 1'b0;
            buf_q      <= '0;
        end else begin
            if (buf_wr) begin
                buf_full_q <= 1'b1;
                buf_q      <= buf_wdata;
            end else if (load) begin
                buf_full_q <= 1'b0;
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        tx_dat    = 1'b1;
        sclk_out  = 1'b0;
        unique case (state_q)
            ST_IDLE:  tx_dat = 1'b1;
            ST_START: tx_dat = 1'b0;
            ST_DATA:  tx_dat = sh_q[0];
            ST_STOP:  tx_dat = 1'b1;
            ST_SLO:   tx_dat = sh_q[0];
            ST_SHI: begin
                tx_dat   = sh_q[0];
                sclk_out = ctl.master;
            end
            default:  tx_dat = 1'b1;
        endcase
        sr_empty  = (state_q == ST_IDLE);
        buf_empty = ~buf_full_q;
        dat_oe    = port_en;
        sclk_oe   = port_en & ctl.sync & ctl.master;
    end

endmodule

// File: rtl/dmtx_checker.sv
module dmtx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_rdata,
    input logic       rx_single,
    input logic       rx_cont,
    input logic       port_en,
    input logic       tx_dat,
    input logic       dat_oe,
    input logic       sclk_out,
    input logic       sclk_oe,
    input logic       buf_empty,
    input logic       sr_empty
);

    a_r11_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (!dat_oe && !sclk_oe));

    a_r7_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        sr_empty |-> !sclk_out);

    a_r4_line_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        sr_empty |-> tx_dat);

    a_r3_load_needs_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_empty) |-> $past(!buf_empty));

    a_r10_rx_override: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[4] && (rx_single || rx_cont)) |=> sr_empty);

    a_r12_txen_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[5] |=> sr_empty);

    a_r8_no_clk_unless_master: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rdata[7] || !ctl_rdata[4]) |-> !sclk_oe);

endmodule

bind dmtx_serial_tx dmtx_checker u_dmtx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rdata (ctl_rdata),
    .rx_single (rx_single),
    .rx_cont   (rx_cont),
    .port_en   (port_en),
    .tx_dat    (tx_dat),
    .dat_oe    (dat_oe),
    .sclk_out  (sclk_out),
    .sclk_oe   (sclk_oe),
    .buf_empty (buf_empty),
    .sr_empty  (sr_empty)
);

// File: tb/dmtx_serial_tx_bench.sv
`timescale 1ns/1ps
module dmtx_serial_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       baud_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       rx_single = 1'b0;
    logic       rx_cont = 1'b0;
    logic       port_en = 1'b0;
    logic       tx_dat, dat_oe, sclk_out, sclk_oe, buf_empty, sr_empty;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int tick_div = 1;
    int tick_ph = 0;
    bit chk_on = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dmtx_serial_tx u_dmtx_serial_tx (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .baud_tick(baud_tick), .ext_clk(ext_clk), .rx_single(rx_single),
        .rx_cont(rx_cont), .port_en(port_en), .tx_dat(tx_dat), .dat_oe(dat_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .buf_empty(buf_empty),
        .sr_empty(sr_empty)
    );

    always @(negedge clk) begin
        tick_ph   = tick_ph + 1;
        baud_tick = ((tick_ph % tick_div) == 0);
    end

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model (phase: 0 idle,1 start,2 data,3 stop,4 sync low,5 sync high)
    int m_ph, m_cnt, m_idx, m_n;
    logic [8:0] m_sh;
    logic [7:0] m_buf;
    bit m_bfull, m_master, m_nine, m_txen, m_sync, m_fast, m_ninth;
    bit m_s1, m_s2, m_s3;

    always @(posedge clk) begin : model
        bit go, rise, fall, done, load;
        int lim, np;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_n = 8; m_sh = '0; m_buf = '0;
            m_bfull = 0; m_master = 0; m_nine = 0; m_txen = 0; m_sync = 0;
            m_fast = 0; m_ninth = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            go   = m_txen && !(m_sync && (rx_single || rx_cont));
            rise = m_s2 && !m_s3;
            fall = !m_s2 && m_s3;
            lim  = m_fast ? 16 : 64;
            done = (m_ph >= 1 && m_ph <= 3) && baud_tick && (m_cnt == lim - 1);
            load = 0;
            np   = m_ph;
            if (m_ph != 0 && !go) np = 0;
            else begin
                case (m_ph)
                    0: if (m_bfull && go) begin
                           load = 1; m_sh = {m_ninth, m_buf}; m_idx = 0;
                           m_n = m_nine ? 9 : 8; np = m_sync ? 4 : 1;
                       end
                    1: if (done) np = 2;
                    2: if (done) begin
                           if (m_idx == m_n - 1) np = 3;
                           else begin m_sh = m_sh >> 1; m_idx++; end
                       end
                    3: if (done) np = 0;
                    4: if (m_master ? baud_tick : rise) np = 5;
                    5: if (m_master ? baud_tick : fall) begin
                           if (m_idx == m_n - 1) np = 0;
                           else begin m_sh = m_sh >> 1; m_idx++; np = 4; end
                       end
                    default: np = 0;
                endcase
            end
            if (!(m_ph >= 1 && m_ph <= 3) || done) m_cnt = 0;
            else if (baud_tick) m_cnt++;
            m_ph = np;
            if (buf_wr) begin m_bfull = 1; m_buf = buf_wdata; end
            else if (load) m_bfull = 0;
            if (ctl_wr) begin
                m_master = ctl_wdata[7]; m_nine = ctl_wdata[6]; m_txen = ctl_wdata[5];
                m_sync = ctl_wdata[4]; m_fast = ctl_wdata[2]; m_ninth = ctl_wdata[0];
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
        end
    end

    // Per-cycle comparison against the model.
    always @(posedge clk) begin
        #3;
        if (chk_on && !finished) begin
            chk("R4 tx_dat", {8'd0, tx_dat},
                {8'd0, (m_ph == 1) ? 1'b0 : (m_ph == 2 || m_ph >= 4) ? m_sh[0] : 1'b1});
            chk("R7 sclk_out", {8'd0, sclk_out}, {8'd0, (m_ph == 5) && m_master});
            chk("R12 sr_empty", {8'd0, sr_empty}, {8'd0, m_ph == 0});
            chk("R3 buf_empty", {8'd0, buf_empty}, {8'd0, !m_bfull});
            chk("R2 ctl_rdata", {1'b0, ctl_rdata},
                {1'b0, m_master, m_nine, m_txen, m_sync, 1'b0, m_fast, m_ph == 0, m_ninth});
            chk("R11 output enables", {7'd0, dat_oe, sclk_oe},
                {7'd0, port_en, port_en && m_sync && m_master});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog expired for all requirements actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", total, fails);
            $finish;
        end
    end

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic buf_write(input logic [7:0] v);
        @(negedge clk); buf_wr = 1; buf_wdata = v;
        @(negedge clk); buf_wr = 0;
    endtask

    task automatic sample;
        @(posedge clk); #3;
    endtask

    task automatic wait_idle;
        do sample(); while (!(sr_empty && buf_empty));
    endtask

    task automatic busy_len(output int n, output int pulses);
        logic prev;
        n = 0; pulses = 0;
        do sample(); while (sr_empty);
        prev = sclk_out;
        while (!sr_empty) begin
            n++;
            if (sclk_out && !prev) pulses++;
            prev = sclk_out;
            sample();
        end
    endtask

    initial begin
        int n, p, n2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        sample();
        chk("R1 reset ctl", {1'b0, ctl_rdata}, 9'h002);
        chk("R1 reset line/clk/flags", {5'd0, tx_dat, sclk_out, buf_empty, sr_empty}, 9'h00B);

        // R2 layout readback; shifter-empty bit not writable
        ctl_write(8'hFD); sample();
        chk("R2 write FD readback", {1'b0, ctl_rdata}, 9'h0F7);
        ctl_write(8'h00); sample();
        chk("R2 write 00 readback", {1'b0, ctl_rdata}, 9'h002);

        // R11 port disabled
        chk("R11 oe off", {7'd0, dat_oe, sclk_oe}, 9'h000);
        port_en = 1;

        // R3 load timing
        tick_div = 2;
        ctl_write(8'h24);
        @(negedge clk); buf_wr = 1; buf_wdata = 8'hC3;
        sample();
        chk("R3 buffer full after write", {7'd0, buf_empty, sr_empty}, 9'h001);
        @(negedge clk); buf_wr = 0;
        sample();
        chk("R3 transfer", {7'd0, buf_empty, sr_empty}, 9'h002);
        buf_write(8'h81);
        sample();
        chk("R3 second byte waits", {8'd0, buf_empty}, 9'h000);
        wait_idle();

        // R5 fast 8-bit, R4 frame content via model
        tick_div = 1;
        buf_write(8'hA5); busy_len(n, p);
        chk("R5 fast frame length", 9'(n), 9'd160);
        // R6 nine-bit frame
        ctl_write(8'h65); buf_write(8'h3C); busy_len(n, p);
        chk("R6 nine-bit frame length", 9'(n), 9'd176);
        // R5 slow
        ctl_write(8'h20); buf_write(8'h5A); busy_len(n, p);
        chk("R5 slow frame length", 10'(n) == 10'd640 ? 9'd1 : 9'd0, 9'd1);
        // R10 async ignores rx requests; R8 master bit ignored in async
        ctl_write(8'hA4); rx_cont = 1;
        buf_write(8'h0F); busy_len(n, p);
        chk("R10 async rx ignored length", 9'(n), 9'd160);
        chk("R8 async no clock pulses", 9'(p), 9'd0);
        rx_cont = 0;

        // R10 transmit disabled holds buffer
        ctl_write(8'h04); buf_write(8'h77);
        repeat (40) sample();
        chk("R10 txen off holds", {7'd0, buf_empty, sr_empty}, 9'h001);
        ctl_write(8'h24); busy_len(n, p);
        chk("R10 sends after enable", 9'(n), 9'd160);
        wait_idle();

        // R7 sync master
        ctl_write(8'hB0); sample();
        chk("R7 clock oe master", {8'd0, sclk_oe}, 9'h001);
        buf_write(8'h96); busy_len(n, p);
        chk("R7 eight pulses", 9'(p), 9'd8);
        chk("R9 master length fast clear", 9'(n), 9'd16);
        ctl_write(8'hB4); buf_write(8'h96); busy_len(n2, p);
        chk("R9 master length fast set", 9'(n2), 9'd16);
        ctl_write(8'hF1); buf_write(8'h13); busy_len(n, p);
        chk("R7 nine pulses", 9'(p), 9'd9);
        tick_div = 3;
        ctl_write(8'hB0); buf_write(8'hE1); busy_len(n, p);
        chk("R7 pulses slow tick", 9'(p), 9'd8);

        // R10 receive override in sync
        rx_cont = 1; buf_write(8'h44);
        repeat (30) sample();
        chk("R10 rx blocks load", {7'd0, buf_empty, sr_empty}, 9'h001);
        @(negedge clk); rx_cont = 0;
        repeat (6) sample();
        chk("R10 word started", {8'd0, sr_empty}, 9'h000);
        @(negedge clk); rx_single = 1;
        sample();
        chk("R10 word cancelled", {8'd0, sr_empty}, 9'h001);
        @(negedge clk); rx_single = 0;
        wait_idle();

        // R12 clearing txen mid-word
        tick_div = 4;
        ctl_write(8'hB0); buf_write(8'h55);
        repeat (3) sample();
        ctl_write(8'h90); sample();
        chk("R12 txen clear empties", {8'd0, sr_empty}, 9'h001);

        // R8 sync slave
        ctl_write(8'h30); sample();
        chk("R8 slave no clock oe", {8'd0, sclk_oe}, 9'h000);
        buf_write(8'h5A);
        for (int i = 0; i < 20; i++) begin
            repeat (4) @(negedge clk);
            ext_clk = ~ext_clk;
        end
        repeat (6) sample();
        chk("R8 slave word done", {7'd0, sr_empty, sclk_out}, 9'h002);

        // R11 port disabled in master mode
        ctl_write(8'hB0); @(negedge clk); port_en = 0; sample();
        chk("R11 oe off master", {7'd0, dat_oe, sclk_oe}, 9'h000);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

endmodule